// File: doc/BRIEF.md
# Event timer comparator channel

One comparator channel of a multi-channel event timer. The channel watches a shared, free-running 64-bit tick count supplied from outside. It raises an interrupt when that count reaches a programmed comparator value. Software sets the channel up through a small configuration word and writes the comparator in 32-bit halves. A global run input enables or halts interrupt generation for every channel at once.

Each channel runs in one of two modes. In one-shot mode it fires once. In periodic mode it reloads itself from a hidden period register. When software sets a set-value bit, the next comparator write also loads the comparator directly. A 32-bit mode compares only the low half of the count. In 32-bit one-shot use, the channel raises an extra interrupt when the count wraps past all-ones before it reaches the comparator. Interrupts are signalled as a held level, which sets a status bit, or as a single-cycle pulse.

There is no streaming data path here. Every pin is a plain control or status signal, and no pin has a valid/ready handshake or back-pressure.

Top module: `evt_chan`

## Requirements
- R1: In one-shot mode (config bit 1 = 0), `irq_o` first shows high in the cycle after the one in which `tick_i` equals the comparator. The channel then disarms and does not fire again until it is re-armed. Re-arming happens on a comparator write, on a rising channel enable or on a rising `run_i`.
- R2: In periodic mode (config bit 1 = 1), a comparator write loads the period register. The comparator itself is loaded only when the set-value bit (config bit 4) is 1. Any comparator write clears the set-value bit.
- R3: In periodic mode, the value loaded into the period has its top bit cleared. In 32-bit mode (config bit 3 = 1) that is bit 31. In 64-bit mode it is bit 63, which is bit 31 of a high-half write (`cmp_hi_i` = 1).
- R4: On a periodic match with a non-zero period, the comparator advances by the period. It keeps advancing, one step per cycle, until it lies after the count, and this catch-up raises no further interrupts. In 32-bit mode each sum is cut to 32 bits.
- R5: The test for "reached" takes the signed difference between comparator and count, at 32 or 64 bits according to the mode. A zero or negative distance when the channel is armed makes it fire straight away.
- R6: When the channel is armed in one-shot 32-bit mode with a comparator that lies beyond the next wrap of the low 32 bits, an interrupt fires as the count wraps to zero. The real match then follows as a second interrupt.
- R7: A configuration write with the 32-bit bit set clears the upper halves of the comparator and the period. High-half comparator writes are ignored while 32-bit mode is on.
- R8: In level mode (config bit 2 = 1), a match sets `sts_o` and holds `irq_o` high until the interrupt is cleared. The status bit never rises in edge mode.
- R9: In edge mode (config bit 2 = 0), a match gives a one-cycle pulse on `irq_o` and leaves `sts_o` at 0.
- R10: `irq_o` and `sts_o` drop in the cycle after any of these: the channel enable (config bit 0) is 0, `run_i` is 0, or `sts_clr_i` is pulsed with no match in the same cycle. The same holds in reset.
- R11: A rising channel enable re-arms the compare. While the enable is off, no match is pending or signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 64 | Shared free-running tick count |
| run_i | input | 1 | Global enable for interrupt generation |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 5 | Config: bit0 enable, bit1 periodic, bit2 level, bit3 32-bit mode, bit4 set-value |
| cmp_we_i | input | 1 | Comparator half write strobe |
| cmp_hi_i | input | 1 | 1 selects the upper half, 0 the lower half |
| cmp_wdata_i | input | 32 | Comparator half data |
| sts_clr_i | input | 1 | Write-one pulse that clears the channel status |
| irq_o | output | 1 | Interrupt request |
| sts_o | output | 1 | Channel interrupt status (level mode only) |

## Verification
The assertions assume that writes arrive one at a time, so a configuration write, a comparator write and a status clear never share a cycle. They also assume that the tick count steps up by one per cycle, apart from deliberate jumps. Wrap detection only works if bit 31 of the count is seen high before it falls. The stimulus keeps to this. Every write goes through its own task and lasts exactly one cycle. The count is reloaded only with a clear margin before or after the comparator, and the wrap case approaches all-ones in single steps.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef struct packed {
    logic setval;
    logic mode32;
    logic level;
    logic periodic;
    logic en;
  } chcfg_t;

  localparam int unsigned CFG_W = $bits(chcfg_t);

endpackage

// File: rtl/evt_cfg.sv
module evt_cfg
  import evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             cmp_we_i,
  output chcfg_t           cfg_o,
  output logic             en_rise_o,
  output logic             trunc_o
);

  chcfg_t cfg_q;
  chcfg_t wr_cfg;

  assign wr_cfg = chcfg_t'(cfg_wdata_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= wr_cfg;
      // a comparator access always consumes the set-value request
      if (cmp_we_i) cfg_q.setval <= 1'b0;
    end
  end

  assign cfg_o     = cfg_q;
  assign en_rise_o = cfg_we_i && wr_cfg.en && !cfg_q.en;
  assign trunc_o   = cfg_we_i && wr_cfg.mode32;

endmodule

// File: rtl/evt_cmp.sv
module evt_cmp #(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               periodic_i,
  input  logic               mode32_i,
  input  logic               setval_i,
  input  logic               wr_i,
  input  logic               hi_i,
  input  logic [CNT_W/2-1:0] wdata_i,
  input  logic               trunc_i,
  input  logic               adv_i,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [CNT_W-1:0]   period_o
);

  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cmp_q, period_q;
  logic [CNT_W-1:0]  sum, sum_trim;
  logic [HALF_W-1:0] lo_masked, hi_masked;
  logic              load_cmp;

  assign load_cmp  = !periodic_i || setval_i;
  assign hi_masked = {1'b0, wdata_i[HALF_W-2:0]};
  assign lo_masked = mode32_i ? hi_masked : wdata_i;
  assign sum       = cmp_q + period_q;
  assign sum_trim  = mode32_i ? {{HALF_W{1'b0}}, sum[HALF_W-1:0]} : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      period_q <= '0;
    end else begin
      if (adv_i) cmp_q <= sum_trim;
      if (wr_i) begin
        if (!hi_i) begin
          if (load_cmp)   cmp_q[HALF_W-1:0]    <= wdata_i;
          if (periodic_i) period_q[HALF_W-1:0] <= lo_masked;
        end else if (!mode32_i) begin
          if (load_cmp)   cmp_q[CNT_W-1:HALF_W]    <= wdata_i;
          if (periodic_i) period_q[CNT_W-1:HALF_W] <= hi_masked;
        end
      end
      if (trunc_i) begin
        cmp_q[CNT_W-1:HALF_W]    <= '0;
        period_q[CNT_W-1:HALF_W] <= '0;
      end
    end
  end

  assign cmp_o    = cmp_q;
  assign period_o = period_q;

endmodule

// File: rtl/evt_match.sv
module evt_match #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             mode32_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             arm_evt_i,
  output logic             active_o,
  output logic             fire_o,
  output logic             wrap_fire_o,
  output logic             adv_o,
  output logic             armed_o
);

  localparam int unsigned HALF_W = CNT_W / 2;

  logic             run_q, arm_q, armed_q, catch_q, wrap_q, msb_q;
  logic [CNT_W-1:0] diff;
  logic             due, active, run_rise, reload, ok;
  logic             wrap_hit, match_hit, wrap_start;

  assign diff     = cmp_i - tick_i;
  assign due      = mode32_i ? (diff[HALF_W-1] || diff[HALF_W-1:0] == '0)
                             : (diff[CNT_W-1]  || diff == '0);
  assign active   = en_i && run_i;
  assign run_rise = run_i && !run_q;
  assign reload   = periodic_i && (period_i != '0);

  assign wrap_hit   = wrap_q && msb_q && !tick_i[HALF_W-1];
  assign match_hit  = due && !wrap_q;
  assign ok         = active && armed_q && !arm_q && !catch_q;
  assign wrap_start = mode32_i && !periodic_i && !due &&
                      (cmp_i[HALF_W-1:0] < tick_i[HALF_W-1:0]);

  assign fire_o      = ok && (wrap_hit || match_hit);
  assign wrap_fire_o = ok && wrap_hit;
  assign adv_o       = (ok && match_hit && reload) || (active && catch_q && due);
  assign active_o    = active;
  assign armed_o     = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      arm_q   <= 1'b0;
      armed_q <= 1'b0;
      catch_q <= 1'b0;
      wrap_q  <= 1'b0;
      msb_q   <= 1'b0;
    end else begin
      run_q <= run_i;
      msb_q <= tick_i[HALF_W-1];
      arm_q <= arm_evt_i || run_rise;
      if (!active) begin
        armed_q <= 1'b0;
        catch_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (arm_q) begin
        armed_q <= 1'b1;
        catch_q <= 1'b0;
        wrap_q  <= wrap_start;
      end else begin
        if (ok && wrap_hit) begin
          wrap_q <= 1'b0;
        end else if (ok && match_hit) begin
          if (reload) catch_q <= 1'b1;
          else        armed_q <= 1'b0;
        end
        if (catch_q && !due) catch_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/evt_irq.sv
module evt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic level_i,
  input  logic fire_i,
  input  logic sts_clr_i,
  output logic irq_o,
  output logic sts_o
);

  logic sts_q, pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (!active_i) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_i && !level_i;
      if (!level_i)       sts_q <= 1'b0;
      else if (fire_i)    sts_q <= 1'b1;
      else if (sts_clr_i) sts_q <= 1'b0;
    end
  end

  assign irq_o = sts_q | pulse_q;
  assign sts_o = sts_q;

endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   tick_i,
  input  logic               run_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               cmp_we_i,
  input  logic               cmp_hi_i,
  input  logic [CNT_W/2-1:0] cmp_wdata_i,
  input  logic               sts_clr_i,
  output logic               irq_o,
  output logic               sts_o
);

  chcfg_t           cfg_q;
  logic             en_rise, trunc, active, fire, wrap_fire, adv, armed;
  logic [CNT_W-1:0] cmp_q, period_q;

  evt_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cmp_we_i   (cmp_we_i),
    .cfg_o      (cfg_q),
    .en_rise_o  (en_rise),
    .trunc_o    (trunc)
  );

  evt_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .periodic_i(cfg_q.periodic),
    .mode32_i  (cfg_q.mode32),
    .setval_i  (cfg_q.setval),
    .wr_i      (cmp_we_i),
    .hi_i      (cmp_hi_i),
    .wdata_i   (cmp_wdata_i),
    .trunc_i   (trunc),
    .adv_i     (adv),
    .cmp_o     (cmp_q),
    .period_o  (period_q)
  );

  evt_match #(.CNT_W(CNT_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (cfg_q.en),
    .periodic_i (cfg_q.periodic),
    .mode32_i   (cfg_q.mode32),
    .run_i      (run_i),
    .tick_i     (tick_i),
    .cmp_i      (cmp_q),
    .period_i   (period_q),
    .arm_evt_i  (en_rise | cmp_we_i),
    .active_o   (active),
    .fire_o     (fire),
    .wrap_fire_o(wrap_fire),
    .adv_o      (adv),
    .armed_o    (armed)
  );

  evt_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .level_i  (cfg_q.level),
    .fire_i   (fire),
    .sts_clr_i(sts_clr_i),
    .irq_o    (irq_o),
    .sts_o    (sts_o)
  );

endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_i,
  input logic               sts_clr_i,
  input logic               cmp_we_i,
  input logic               cmp_hi_i,
  input logic               irq_o,
  input logic               sts_o,
  input logic               en,
  input logic               level,
  input logic               periodic,
  input logic               mode32,
  input logic               setval,
  input logic               fire,
  input logic               wrap_fire,
  input logic               armed,
  input logic               trunc,
  input logic [CNT_W/2-1:0] cmp_hi_half,
  input logic [CNT_W/2-1:0] per_hi_half,
  input logic               per_lo_top
);

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !periodic && !wrap_fire |=> !armed); // R1

  AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i |=> !setval); // R2

  AST_PERIOD_TOP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i && !cmp_hi_i && periodic && mode32 |=> !per_lo_top); // R3

  AST_TRUNC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |=> (cmp_hi_half == '0) && (per_hi_half == '0)); // R7

  AST_STATUS_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o) |-> $past(level)); // R8

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !sts_o && !fire |=> !irq_o); // R9

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr_i && !fire |=> !sts_o); // R10

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && run_i) |=> !irq_o); // R10

endmodule

bind evt_chan evt_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_i      (run_i),
  .sts_clr_i  (sts_clr_i),
  .cmp_we_i   (cmp_we_i),
  .cmp_hi_i   (cmp_hi_i),
  .irq_o      (irq_o),
  .sts_o      (sts_o),
  .en         (cfg_q.en),
  .level      (cfg_q.level),
  .periodic   (cfg_q.periodic),
  .mode32     (cfg_q.mode32),
  .setval     (cfg_q.setval),
  .fire       (fire),
  .wrap_fire  (wrap_fire),
  .armed      (armed),
  .trunc      (trunc),
  .cmp_hi_half(cmp_q[CNT_W-1:CNT_W/2]),
  .per_hi_half(period_q[CNT_W-1:CNT_W/2]),
  .per_lo_top (period_q[CNT_W/2-1])
);

// File: tb/sim_evt_chan.sv
module sim_evt_chan;
  import evt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt, ldv;
  logic        ld = 1'b0;
  logic        run = 1'b1, cfg_we = 1'b0, cmp_we = 1'b0, cmp_hi = 1'b0, clr = 1'b0;
  logic [CFG_W-1:0] cfg_d = '0;
  logic [31:0] cmp_d = '0;
  logic        irq, sts;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (ld) cnt <= ldv;
    else         cnt <= cnt + 64'd1;
  end

  evt_chan u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(cnt), .run_i(run),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_d), .cmp_we_i(cmp_we),
    .cmp_hi_i(cmp_hi), .cmp_wdata_i(cmp_d), .sts_clr_i(clr),
    .irq_o(irq), .sts_o(sts)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_w(input logic [CFG_W-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_d = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cmp_w(input logic hi, input logic [31:0] d);
    @(negedge clk); cmp_we = 1'b1; cmp_hi = hi; cmp_d = d;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic load(input logic [63:0] v);
    @(negedge clk); ld = 1'b1; ldv = v;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic wait_irq(input logic [63:0] exp, input string tag);
    bit seen = 1'b0;
    for (int n = 0; n < 1000 && !seen; n++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk(seen && cnt == exp, tag, seen ? cnt : 64'hdead, exp);
  endtask

  task automatic wait_soon(input int lim, input string tag);
    bit seen = 1'b0;
    for (int n = 0; n < lim && !seen; n++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk(seen, tag, seen, 1);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic t_oneshot();
    cfg_w(5'b00000); cmp_w(1'b1, 32'd0); cmp_w(1'b0, 32'd100); load(64'd0);
    cfg_w(5'b00001);
    wait_irq(64'd101, "R1 one-shot match cycle");
    @(negedge clk);
    chk(!irq, "R9 edge pulse lasts one cycle", irq, 0);
    chk(!sts, "R9 edge leaves status clear", sts, 0);
    quiet(300, "R1 one-shot fires once");
  endtask

  task automatic t_level();
    cfg_w(5'b00000); load(64'd0); cmp_w(1'b0, 32'd60);
    cfg_w(5'b00101);
    wait_irq(64'd61, "R8 level match");
    chk(sts, "R8 status set", sts, 1);
    repeat (5) @(negedge clk);
    chk(irq && sts, "R8 level held", {irq, sts}, 2'b11);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(!irq && !sts, "R10 status clear write", {irq, sts}, 0);
    load(64'd0); cmp_w(1'b0, 32'd80);
    wait_irq(64'd81, "R8 level match after rearm");
    cfg_w(5'b00000);
    @(negedge clk);
    chk(!irq && !sts, "R10 channel disable clears", {irq, sts}, 0);
    cfg_w(5'b00101);
    wait_soon(4, "R11 enable rearms, overdue fires at once");
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    chk(!irq && !sts, "R10 global off clears", {irq, sts}, 0);
    cfg_w(5'b00000);
    @(negedge clk); run = 1'b1;
  endtask

  task automatic t_periodic();
    cfg_w(5'b00000); load(64'd0);
    cfg_w(5'b10010); cmp_w(1'b0, 32'd200);
    cfg_w(5'b00011);
    wait_irq(64'd201, "R2 set-value loads comparator");
    wait_irq(64'd401, "R4 periodic reload");
    cmp_w(1'b0, 32'd50);
    wait_irq(64'd601, "R2 period-only write keeps comparator");
    wait_irq(64'd651, "R2 new period used");
    cmp_w(1'b0, 32'd20);
    load(64'd735);
    wait_irq(64'd736, "R4 late match fires once");
    wait_irq(64'd741, "R4 catch-up lands after count, no extra irq");
  endtask

  task automatic t_mask();
    cfg_w(5'b00000); cfg_w(5'b11010);
    cmp_w(1'b0, 32'h8000_0010);
    load(64'h8000_0000);
    cfg_w(5'b01011);
    wait_irq(64'h8000_0011, "R3 first periodic match");
    wait_irq(64'h8000_0021, "R3 period top bit masked");
  endtask

  task automatic t_wrap();
    cfg_w(5'b00000); cfg_w(5'b01000);
    cmp_w(1'b0, 32'h10);
    load(64'h0_FFFF_FF00);
    cfg_w(5'b01001);
    wait_irq(64'h1_0000_0001, "R6 wrap interrupt");
    wait_irq(64'h1_0000_0011, "R6 real match after wrap");
    quiet(100, "R6 nothing further");
  endtask

  task automatic t_rearm();
    cfg_w(5'b00000); cmp_w(1'b1, 32'd0); cmp_w(1'b0, 32'd500); load(64'd0);
    cfg_w(5'b00001);
    repeat (20) @(negedge clk);
    cfg_w(5'b00000);
    load(64'd490);
    quiet(60, "R11 disabled channel has no pending match");
    cfg_w(5'b00001);
    wait_soon(4, "R5 negative distance fires at once after R11 rearm");
  endtask

  task automatic t_trunc();
    cfg_w(5'b00000); cmp_w(1'b1, 32'd1); cmp_w(1'b0, 32'h20);
    cfg_w(5'b01000);
    cmp_w(1'b1, 32'd7);
    cfg_w(5'b00000); load(64'd0);
    cfg_w(5'b00001);
    wait_irq(64'h21, "R7 upper half cleared and high write ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all R) actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!irq, "R10 irq low in reset", irq, 0);
    chk(!sts, "R10 status low in reset", sts, 0);
    rst_n = 1'b1;
    t_oneshot();
    t_level();
    t_periodic();
    t_mask();
    t_wrap();
    t_rearm();
    t_trunc();
    report();
  end

endmodule